// File: doc/BRIEF.md
# Indexed Interrupt Enable Controller

This block is the per-CPU front end of an interrupt controller, driven from a 32-bit register port. It keeps one global on/off bit, one enable bit and one mask bit per source, and a one-bit priority gate. Software never rewrites a whole bitmap. It writes the number of a single source to a dedicated register, and that write enables, disables, masks or unmasks that source alone.

The sources are level inputs. In every cycle the block finds the lowest-numbered source that is pending, enabled and unmasked, provided the controller is on and the priority gate is open. The acknowledge register returns that source's ID, or the all-ones code when no source qualifies. The CPU interrupt line is the registered-state view of the same decision.

Top module: `idx_irq_ctrl`

## Requirements
- R1: After reset the global enable reads 0, the priority register reads 1, and every source is disabled and masked. The acknowledge register reads 0x3FF and the interrupt output is low, even when sources are pending and the gate is later opened.
- R2: Writing to offset 0x000 sets the global enable to bit 0 of the write data. While the global enable is 0, no source is reported.
- R3: Writing a source number to offset 0x030 enables that source. Writing a source number to offset 0x034 disables it. No other source is affected.
- R4: Writing a source number to offset 0x0B8 masks that source. Writing a source number to offset 0x0BC unmasks it. A masked source is not reported.
- R5: A read at offset 0x0B4 returns the selected source ID in bits [9:0] and zeros above. The value 0x3FF means that nothing qualifies.
- R6: The priority register at offset 0x0B0 takes bit 0 of the write data. While it holds 1, no source is reported. While it holds 0, delivery is allowed.
- R7: When several sources qualify, the lowest source number is reported.
- R8: The output cpuIrq is high exactly when the acknowledge value differs from 0x3FF.
- R9: An enable, disable, mask or unmask write whose full 32-bit data is not below NUM_SRC changes no state. This holds even when the low bits of the data equal a valid source number.
- R10: Sources are level-sensitive. When a reported source's input falls, the report moves to the next qualifying source, or to 0x3FF, without any register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational on address |
| srcLevel | input | NUM_SRC | Level of each interrupt source |
| cpuIrq | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with the default NUM_SRC of 128. This puts the top index, 127, in reach as a valid source and 128 as the first rejected value. The bench also writes the values 128 and 0x400, whose low seven bits alias source 0. This exposes any decoder that truncates the index before it checks the range. Sources 0, 3, 5 and 127 are driven in overlapping patterns, so the lowest-number rule and the level-drop behaviour are both seen switching.

// File: rtl/idx_irq_pkg.sv
package idx_irq_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ_ID = '1;

  localparam logic [11:0] OFS_GLOBAL = 12'h000;
  localparam logic [11:0] OFS_EN_SET = 12'h030;
  localparam logic [11:0] OFS_EN_CLR = 12'h034;
  localparam logic [11:0] OFS_PRIO   = 12'h0B0;
  localparam logic [11:0] OFS_ACK    = 12'h0B4;
  localparam logic [11:0] OFS_MSK_SET = 12'h0B8;
  localparam logic [11:0] OFS_MSK_CLR = 12'h0BC;

  typedef enum logic [1:0] {RD_ZERO, RD_GLOBAL, RD_PRIO, RD_ACK} rd_sel_e;

  typedef struct packed {
    logic            globalWr;
    logic            prioWr;
    logic            enSet;
    logic            enClr;
    logic            mskSet;
    logic            mskClr;
    logic            idxOk;
    logic            wrBit;
    logic [ID_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/idx_irq_decode.sv
module idx_irq_decode
  import idx_irq_pkg::*;
#(
  parameter int NUM_SRC = 128
) (
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [11:0] regAddr,
  input  logic [31:0] regWrData,
  output strobe_t     stb,
  output rd_sel_e     rdSel
);
  localparam logic [31:0] SRC_LIMIT = 32'(NUM_SRC);

  always_comb begin
    stb          = '0;
    stb.wrBit    = regWrData[0];
    stb.idx      = regWrData[ID_W-1:0];
    stb.idxOk    = regWrData < SRC_LIMIT;   // full-width range check (R9)
    if (regWrEn) begin
      stb.globalWr = (regAddr == OFS_GLOBAL);
      stb.prioWr   = (regAddr == OFS_PRIO);
      stb.enSet    = (regAddr == OFS_EN_SET);
      stb.enClr    = (regAddr == OFS_EN_CLR);
      stb.mskSet   = (regAddr == OFS_MSK_SET);
      stb.mskClr   = (regAddr == OFS_MSK_CLR);
    end
  end

  always_comb begin
    rdSel = RD_ZERO;
    if (regRdEn) begin
      unique case (regAddr)
        OFS_GLOBAL: rdSel = RD_GLOBAL;
        OFS_PRIO:   rdSel = RD_PRIO;
        OFS_ACK:    rdSel = RD_ACK;
        default:    rdSel = RD_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/idx_irq_datapath.sv
module idx_irq_datapath
  import idx_irq_pkg::*;
#(
  parameter int NUM_SRC = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            stb,
  input  rd_sel_e            rdSel,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic [31:0]        rdData,
  output logic               cpuIrq
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic               globalOn;
  logic               prioBlock;
  logic [NUM_SRC-1:0] enReg;
  logic [NUM_SRC-1:0] mskReg;
  logic [NUM_SRC-1:0] selBit;
  logic [NUM_SRC-1:0] eligible;
  logic [ID_W-1:0]    ackId;
  logic [NUM_SRC-1:0] ackOneHot;

  assign selBit = NUM_SRC'(1) << stb.idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      globalOn  <= 1'b0;
      prioBlock <= 1'b1;
      enReg     <= '0;
      mskReg    <= '1;
    end else begin
      if (stb.globalWr) globalOn  <= stb.wrBit;
      if (stb.prioWr)   prioBlock <= stb.wrBit;
      if (stb.idxOk) begin
        if (stb.enSet)  enReg  <= enReg | selBit;
        if (stb.enClr)  enReg  <= enReg & ~selBit;
        if (stb.mskSet) mskReg <= mskReg | selBit;
        if (stb.mskClr) mskReg <= mskReg & ~selBit;
      end
    end
  end

  assign eligible = srcLevel & enReg & ~mskReg & {NUM_SRC{globalOn & ~prioBlock}};

  // Scan from the top down so the lowest qualifying source is the last one kept.
  always_comb begin
    ackId = NO_IRQ_ID;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) ackId = ID_W'(i);
    end
  end

  assign cpuIrq    = (ackId != NO_IRQ_ID);
  assign ackOneHot = NUM_SRC'(1) << ackId;

  always_comb begin
    unique case (rdSel)
      RD_GLOBAL: rdData = {31'b0, globalOn};
      RD_PRIO:   rdData = {31'b0, prioBlock};
      RD_ACK:    rdData = 32'(ackId);
      default:   rdData = '0;
    endcase
  end

  p_off_silent_r2: assert property (@(posedge clk) disable iff (rst)
    !globalOn |-> ackId == NO_IRQ_ID);
  p_en_set_r3: assert property (@(posedge clk) disable iff (rst)
    stb.enSet && stb.idxOk |=> enReg[$past(stb.idx[IDX_W-1:0])]);
  p_en_clr_r3: assert property (@(posedge clk) disable iff (rst)
    stb.enClr && stb.idxOk |=> !enReg[$past(stb.idx[IDX_W-1:0])]);
  p_msk_set_r4: assert property (@(posedge clk) disable iff (rst)
    stb.mskSet && stb.idxOk |=> mskReg[$past(stb.idx[IDX_W-1:0])]);
  p_ack_valid_r5: assert property (@(posedge clk) disable iff (rst)
    ackId != NO_IRQ_ID |-> |(ackOneHot & srcLevel & enReg & ~mskReg));
  p_prio_block_r6: assert property (@(posedge clk) disable iff (rst)
    prioBlock |-> !cpuIrq);
  p_lowest_r7: assert property (@(posedge clk) disable iff (rst)
    ackId != NO_IRQ_ID |-> ((ackOneHot - NUM_SRC'(1)) & srcLevel & enReg & ~mskReg) == '0);
  p_oob_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (stb.enSet || stb.enClr || stb.mskSet || stb.mskClr) && !stb.idxOk
      |=> $stable(enReg) && $stable(mskReg));
endmodule

// File: rtl/idx_irq_ctrl.sv
module idx_irq_ctrl
  import idx_irq_pkg::*;
#(
  parameter int NUM_SRC = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [11:0]        regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic               cpuIrq
);
  strobe_t stb;
  rd_sel_e rdSel;

  idx_irq_decode #(.NUM_SRC(NUM_SRC)) u_decode (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .stb(stb), .rdSel(rdSel)
  );

  idx_irq_datapath #(.NUM_SRC(NUM_SRC)) u_datapath (
    .clk(clk), .rst(rst), .stb(stb), .rdSel(rdSel), .srcLevel(srcLevel),
    .rdData(regRdData), .cpuIrq(cpuIrq)
  );
endmodule

// File: tb/idx_irq_ctrl_bench.sv
module idx_irq_ctrl_bench;
  localparam int NSRC = 128;
  localparam logic [11:0] A_GLB = 12'h000, A_ENS = 12'h030, A_ENC = 12'h034,
    A_PRI = 12'h0B0, A_ACK = 12'h0B4, A_MSS = 12'h0B8, A_MSC = 12'h0BC;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_SRC = 2'd2, K_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  kind;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 44;
  localparam vec_t VECS[NVEC] = '{
    '{K_RD,  A_ACK, 32'd0,     32'h3FF, 8'd1},  // R1 nothing after reset
    '{K_RD,  A_PRI, 32'd0,     32'd1,   8'd1},  // R1 gate closed
    '{K_RD,  A_GLB, 32'd0,     32'd0,   8'd1},  // R1 global off
    '{K_SRC, 12'd0, 32'd5,     32'd1,   8'd0},
    '{K_WR,  A_ENS, 32'd5,     32'd0,   8'd0},
    '{K_WR,  A_MSC, 32'd5,     32'd0,   8'd0},
    '{K_WR,  A_PRI, 32'd0,     32'd0,   8'd0},
    '{K_RD,  A_ACK, 32'd0,     32'h3FF, 8'd2},  // R2 global still off
    '{K_IRQ, 12'd0, 32'd0,     32'd0,   8'd2},
    '{K_WR,  A_GLB, 32'd1,     32'd0,   8'd0},
    '{K_RD,  A_GLB, 32'd0,     32'd1,   8'd2},
    '{K_RD,  A_ACK, 32'd0,     32'd5,   8'd5},  // R5 ID returned
    '{K_IRQ, 12'd0, 32'd0,     32'd1,   8'd8},  // R8
    '{K_WR,  A_PRI, 32'd1,     32'd0,   8'd0},
    '{K_RD,  A_ACK, 32'd0,     32'h3FF, 8'd6},  // R6 blocked
    '{K_IRQ, 12'd0, 32'd0,     32'd0,   8'd6},
    '{K_WR,  A_PRI, 32'd0,     32'd0,   8'd0},
    '{K_RD,  A_ACK, 32'd0,     32'd5,   8'd6},  // R6 allowed
    '{K_SRC, 12'd0, 32'd3,     32'd1,   8'd0},
    '{K_WR,  A_ENS, 32'd3,     32'd0,   8'd0},
    '{K_WR,  A_MSC, 32'd3,     32'd0,   8'd0},
    '{K_RD,  A_ACK, 32'd0,     32'd3,   8'd7},  // R7 3 beats 5
    '{K_WR,  A_MSS, 32'd3,     32'd0,   8'd0},
    '{K_RD,  A_ACK, 32'd0,     32'd5,   8'd4},  // R4 masked 3 skipped
    '{K_WR,  A_ENC, 32'd5,     32'd0,   8'd0},
    '{K_RD,  A_ACK, 32'd0,     32'h3FF, 8'd3},  // R3 5 disabled
    '{K_WR,  A_MSC, 32'd3,     32'd0,   8'd0},
    '{K_RD,  A_ACK, 32'd0,     32'd3,   8'd4},  // R4 unmask
    '{K_SRC, 12'd0, 32'd3,     32'd0,   8'd0},
    '{K_RD,  A_ACK, 32'd0,     32'h3FF, 8'd10}, // R10 level dropped
    '{K_WR,  A_ENS, 32'd5,     32'd0,   8'd0},
    '{K_SRC, 12'd0, 32'd127,   32'd1,   8'd0},
    '{K_WR,  A_ENS, 32'd127,   32'd0,   8'd0},
    '{K_WR,  A_MSC, 32'd127,   32'd0,   8'd0},
    '{K_SRC, 12'd0, 32'd5,     32'd0,   8'd0},
    '{K_RD,  A_ACK, 32'd0,     32'd127, 8'd10}, // R10 moves to 127
    '{K_SRC, 12'd0, 32'd0,     32'd1,   8'd0},
    '{K_WR,  A_ENS, 32'd0,     32'd0,   8'd0},
    '{K_WR,  A_MSC, 32'd128,   32'd0,   8'd0},
    '{K_WR,  A_MSC, 32'h400,   32'd0,   8'd0},
    '{K_RD,  A_ACK, 32'd0,     32'd127, 8'd9},  // R9 aliases ignored
    '{K_WR,  A_MSC, 32'd0,     32'd0,   8'd0},
    '{K_WR,  A_ENC, 32'd128,   32'd0,   8'd0},
    '{K_RD,  A_ACK, 32'd0,     32'd0,   8'd9}   // R9 and R7: 0 stays enabled
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NSRC-1:0] srcLevel = '0;
  logic cpuIrq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  idx_irq_ctrl #(.NUM_SRC(NSRC)) u_idx_irq_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .srcLevel(srcLevel), .cpuIrq(cpuIrq)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input int req);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 check(req, regRdData, exp);
    regRdEn = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      unique case (VECS[i].kind)
        K_WR:  wr(VECS[i].addr, VECS[i].data);
        K_RD:  rd_check(VECS[i].addr, VECS[i].exp, int'(VECS[i].req));
        K_SRC: begin @(negedge clk); srcLevel[VECS[i].data[6:0]] = VECS[i].exp[0]; end
        default: begin @(negedge clk); #1 check(int'(VECS[i].req), 32'(cpuIrq), VECS[i].exp); end
      endcase
    end
    // R8: the line follows the acknowledge value while source 0 is reported
    @(negedge clk); #1 check(8, 32'(cpuIrq), 32'd1);
    // R2: turning global enable off silences everything
    wr(A_GLB, 32'd0);
    rd_check(A_ACK, 32'h3FF, 2);
    @(negedge clk); #1 check(8, 32'(cpuIrq), 32'd0);
    // R1: a mid-run reset returns to disabled, masked, gated
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd_check(A_PRI, 32'd1, 1);
    rd_check(A_GLB, 32'd0, 1);
    wr(A_GLB, 32'd1);
    wr(A_PRI, 32'd0);
    rd_check(A_ACK, 32'h3FF, 1);
    @(negedge clk); #1 check(1, 32'(cpuIrq), 32'd0);
    // R3: enable alone leaves source 127 masked; unmask then delivers it
    wr(A_ENS, 32'd127);
    rd_check(A_ACK, 32'h3FF, 4);
    wr(A_MSC, 32'd127);
    rd_check(A_ACK, 32'd127, 3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule